// File: doc/BRIEF.md
# SPI Serial Clock Prescaler with Ratio Calculator

This block makes the serial clock of an SPI master from the core clock. The divide ratio is a mantissa times a power of two, `SPR × 2^SPPR`. SPR is a 4-bit mantissa and SPPR is a 3-bit exponent. Because of this, one configuration byte covers ratios from 2 up to 1920 in coarse steps and needs no wide counter limit.

Software, or a higher controller, gives three values: the core clock frequency, the wanted bit rate and an optional bus ceiling. It then pulses `start`. A sequential calculator first applies the ceiling. It then works out the ceiling division of core rate by bit rate, and finds the smallest mantissa/exponent pair whose ratio is not below that divider. It packs the pair into the configuration byte. If no pair fits, it flags the request and keeps the old setting.

A free-running generator reads the configuration byte and divides the core clock by the chosen ratio. It drives `sck` together with a one-cycle strobe that marks each edge. A new ratio takes effect only when the current serial clock period ends.

Top module: `spi_baud_prescaler`

## Requirements
- R1: With a configuration of mantissa M (values below 2 are taken as 2) and exponent E, each `sck` period lasts M·2^E core cycles, and `sck` is high for the first floor(M·2^E/2) of them. `sck_edge` is high in exactly the cycles in which `sck` has just changed.
- R2: The configuration byte holds the mantissa in bits 3:0, exponent bit 0 in bit 4 and exponent bits 2:1 in bits 7:6. Bit 5 is always 0. After reset the byte is 0x0F, a ratio of 15.
- R3: When `max_hz` is nonzero and `req_hz` is above it, the calculation uses `max_hz` in place of `req_hz`. When `max_hz` is zero, or when the request does not exceed it, the request is used as given.
- R4: The divider is ceil(core_hz / rate), raised to 2 if it is smaller. When that divider is below 16, the mantissa equals the divider and the exponent is 0.
- R5: When the divider is 16 or more, the exponent is the smallest E for which ceil(divider / 2^E) is at most 15, and the mantissa is that quotient (so it lies in 8..15). The resulting ratio is never below the divider, so the serial rate never exceeds the request.
- R6: When the effective rate is zero, or when the exponent would have to exceed 7, `err` rises together with `done` and the configuration byte keeps its previous value.
- R7: A `start` that is sampled while idle raises `busy` on the next cycle. `done` is a one-cycle pulse that appears FREQ_W+1 clock edges after the start edge, and `err` is high only together with `done`. A `start` given while busy is ignored.
- R8: A new configuration is applied to the generator only at the end of an `sck` period. Every period is therefore a whole period of either the old ratio or the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a ratio calculation (one-cycle pulse) |
| core_hz | input | FREQ_W | Core clock frequency |
| req_hz | input | FREQ_W | Requested serial bit rate |
| max_hz | input | FREQ_W | Bus rate ceiling, 0 means none |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | Calculation finished (one-cycle pulse) |
| err | output | 1 | Request not reachable, with `done` |
| cfg_byte | output | 8 | Packed mantissa/exponent configuration |
| sck | output | 1 | Serial clock |
| sck_edge | output | 1 | High in the cycle after each `sck` change |

## Verification
The sweep targets the boundary between the plain-mantissa and the exponent ranges (dividers of 15, 16 and 17). It also covers dividers that round up into the next power of two, such as 31 or 63, where a design that skipped the second leading-one search would produce a mantissa of 16 that truncates to zero. Large cores with slow requests push the exponent past 7; a design that wrapped the exponent instead of rejecting it would run the clock far too fast, and one that wrote the byte anyway would lose the previous setting. Odd mantissas with and without an exponent exercise the duty-cycle split, and a ratio change in the middle of a period catches a generator that reloads mid-period and emits one short, glitched cycle.

// File: rtl/baud_pkg.sv
// Package: shared widths, the configuration layout and its pack/unpack helpers.
// Assumes the mantissa/exponent split is fixed at 4/3 bits by the register layout.
package baud_pkg;
    parameter int SPR_W  = 4;
    parameter int SPPR_W = 3;
    parameter int CFG_W  = 8;

    typedef struct packed {
        logic [SPPR_W-1:0] expo;
        logic [SPR_W-1:0]  mant;
    } ratio_t;

    parameter logic [CFG_W-1:0] RESET_CFG = 8'h0F;

    // Place the mantissa and the split exponent into the configuration byte.
    function automatic logic [CFG_W-1:0] pack_cfg(input ratio_t r);
        return {r.expo[2:1], 1'b0, r.expo[0], r.mant};
    endfunction

    // Recover mantissa and exponent from the configuration byte.
    function automatic ratio_t unpack_cfg(input logic [CFG_W-1:0] c);
        ratio_t r;
        r.mant = c[3:0];
        r.expo = {c[7:6], c[4]};
        return r;
    endfunction
endpackage

// File: rtl/baud_calc.sv
// Ratio calculator: clamps the request to the bus ceiling, forms
// ceil(core/rate) with a restoring divider (one quotient bit per cycle) and
// maps it to the smallest mantissa/exponent pair that is not below it.
// Assumes start is a pulse; starts seen while busy are dropped.
module baud_calc
    import baud_pkg::*;
#(
    parameter int FREQ_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FREQ_W-1:0] core_hz,
    input  logic [FREQ_W-1:0] req_hz,
    input  logic [FREQ_W-1:0] max_hz,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [CFG_W-1:0]  cfg_byte
);
    localparam int DIV_W  = FREQ_W + 2;
    localparam int IDX_W  = $clog2(DIV_W) + 1;
    localparam int CNT_W  = $clog2(FREQ_W) + 1;
    localparam int EXP_MX = (1 << SPPR_W) - 1;

    typedef enum logic [1:0] {S_IDLE, S_DIV, S_FIN} st_t;

    st_t               st_q;
    logic [FREQ_W:0]   rem_q;
    logic [FREQ_W-1:0] quo_q;
    logic [FREQ_W-1:0] den_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              zero_q;

    logic [FREQ_W-1:0] rate_eff;
    logic [FREQ_W:0]   trial;
    logic              fits;
    logic [DIV_W-1:0]  div_raw, div_f, mask, rnd, shifted;
    logic [IDX_W-1:0]  sh0, sh1, exp_full;
    logic [SPR_W-1:0]  mant_c;
    logic              err_c;
    ratio_t            res;

    // Index of the highest set bit.
    function automatic logic [IDX_W-1:0] top_bit(input logic [DIV_W-1:0] v);
        logic [IDX_W-1:0] idx;
        idx = '0;
        for (int i = 0; i < DIV_W; i++)
            if (v[i]) idx = IDX_W'(i);
        return idx;
    endfunction

    // Clamp the request to a nonzero ceiling.
    always_comb rate_eff = (max_hz != '0 && req_hz > max_hz) ? max_hz : req_hz;

    // One restoring-division step.
    always_comb begin
        trial = {rem_q[FREQ_W-1:0], quo_q[FREQ_W-1]};
        fits  = trial >= {1'b0, den_q};
    end

    // Map the divider to a mantissa/exponent pair.
    always_comb begin
        div_raw = DIV_W'(quo_q) + DIV_W'(rem_q != '0);
        div_f   = (div_raw < DIV_W'(2)) ? DIV_W'(2) : div_raw;
        sh0     = top_bit(div_f) - IDX_W'(3);
        mask    = (DIV_W'(1) << sh0) - DIV_W'(1);
        rnd     = (div_f + mask) & ~mask;
        sh1     = top_bit(rnd) - IDX_W'(3);
        shifted = rnd >> sh1;
        if (div_f < DIV_W'(16)) begin
            mant_c   = div_f[SPR_W-1:0];
            exp_full = '0;
        end else begin
            mant_c   = shifted[SPR_W-1:0];
            exp_full = sh1;
        end
        err_c    = zero_q || (exp_full > IDX_W'(EXP_MX));
        res.mant = mant_c;
        res.expo = exp_full[SPPR_W-1:0];
    end

    // Sequencer: load, divide, commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= S_IDLE;
            rem_q    <= '0;
            quo_q    <= '0;
            den_q    <= '0;
            cnt_q    <= '0;
            zero_q   <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
            cfg_byte <= RESET_CFG;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (st_q)
                S_IDLE: if (start) begin
                    rem_q  <= '0;
                    quo_q  <= core_hz;
                    den_q  <= rate_eff;
                    zero_q <= (rate_eff == '0);
                    cnt_q  <= '0;
                    st_q   <= S_DIV;
                end
                S_DIV: begin
                    rem_q <= fits ? (trial - {1'b0, den_q}) : trial;
                    quo_q <= {quo_q[FREQ_W-2:0], fits};
                    cnt_q <= cnt_q + CNT_W'(1);
                    if (cnt_q == CNT_W'(FREQ_W - 1)) st_q <= S_FIN;
                end
                S_FIN: begin
                    done <= 1'b1;
                    err  <= err_c;
                    if (!err_c) cfg_byte <= pack_cfg(res);
                    st_q <= S_IDLE;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign busy = (st_q != S_IDLE);
endmodule

// File: rtl/sck_gen.sv
// Serial clock generator: a prescale counter of 2^E cycles nested under a
// mantissa counter of M steps. sck is high for the first half of each period,
// and a new ratio is taken only on the last cycle of a period.
// Assumes mantissas below 2 mean 2, so sck can always toggle.
module sck_gen
    import baud_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_byte,
    output logic             sck,
    output logic             sck_edge
);
    localparam int P_W = (1 << SPPR_W) - 1;

    ratio_t            act_q;
    logic [P_W-1:0]    p_q;
    logic [SPR_W-1:0]  m_q;
    logic [SPR_W-1:0]  mant, half_m;
    logic [P_W-1:0]    pmax, half_p;
    logic              at_start, at_half, at_last;

    // Position decode within the current period.
    always_comb begin
        mant     = (act_q.mant < SPR_W'(2)) ? SPR_W'(2) : act_q.mant;
        pmax     = (P_W'(1) << act_q.expo) - P_W'(1);
        half_m   = mant >> 1;
        half_p   = (mant[0] && act_q.expo != '0) ? (P_W'(1) << (act_q.expo - SPPR_W'(1))) : '0;
        at_start = (m_q == '0) && (p_q == '0);
        at_half  = (m_q == half_m) && (p_q == half_p);
        at_last  = (m_q == mant - SPR_W'(1)) && (p_q == pmax);
    end

    // Counters, boundary reload and registered clock/strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q    <= unpack_cfg(RESET_CFG);
            p_q      <= '0;
            m_q      <= '0;
            sck      <= 1'b0;
            sck_edge <= 1'b0;
        end else begin
            sck_edge <= at_start || at_half;
            if (at_start)     sck <= 1'b1;
            else if (at_half) sck <= 1'b0;
            if (at_last) begin
                p_q   <= '0;
                m_q   <= '0;
                act_q <= unpack_cfg(cfg_byte);
            end else if (p_q == pmax) begin
                p_q <= '0;
                m_q <= m_q + SPR_W'(1);
            end else begin
                p_q <= p_q + P_W'(1);
            end
        end
    end
endmodule

// File: rtl/spi_baud_prescaler.sv
// Top: ratio calculator feeding a serial clock generator through the
// packed configuration byte. Assumes one core clock domain.
module spi_baud_prescaler
    import baud_pkg::*;
#(
    parameter int FREQ_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FREQ_W-1:0] core_hz,
    input  logic [FREQ_W-1:0] req_hz,
    input  logic [FREQ_W-1:0] max_hz,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [7:0]        cfg_byte,
    output logic              sck,
    output logic              sck_edge
);
    baud_calc #(.FREQ_W(FREQ_W)) u_calc (
        .clk(clk), .rst_n(rst_n), .start(start),
        .core_hz(core_hz), .req_hz(req_hz), .max_hz(max_hz),
        .busy(busy), .done(done), .err(err), .cfg_byte(cfg_byte)
    );

    sck_gen u_gen (
        .clk(clk), .rst_n(rst_n), .cfg_byte(cfg_byte),
        .sck(sck), .sck_edge(sck_edge)
    );
endmodule

// File: rtl/spi_baud_prescaler_chk.sv
// Checker: protocol and configuration properties of the prescaler top.
module spi_baud_prescaler_chk #(
    parameter int FREQ_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [FREQ_W-1:0] core_hz,
    input logic [FREQ_W-1:0] req_hz,
    input logic [FREQ_W-1:0] max_hz,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [7:0]        cfg_byte,
    input logic              sck,
    input logic              sck_edge
);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    // R7
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
    // R7
    err_qual_chk: assert property (@(posedge clk) disable iff (!rst_n) err |-> done);
    // R6
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (done && err) |-> $stable(cfg_byte));
    // R2
    cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(cfg_byte));
    // R5
    mant_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && (cfg_byte[4] || cfg_byte[7:6] != 2'b00)) |-> cfg_byte[3]);
    // R1
    edge_mark_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sck) |-> sck_edge);
    // R1
    edge_real_chk: assert property (@(posedge clk) disable iff (!rst_n) sck_edge |-> !$stable(sck));
endmodule

bind spi_baud_prescaler spi_baud_prescaler_chk #(.FREQ_W(FREQ_W)) u_chk (.*);

// File: tb/spi_baud_prescaler_tb.sv
module spi_baud_prescaler_tb;
    localparam int CLK_PERIOD = 10;
    localparam int FREQ_W     = 32;
    localparam int WD_CYCLES  = 190000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [FREQ_W-1:0] core_hz = '0, req_hz = '0, max_hz = '0;
    logic              busy, done, err, sck, sck_edge;
    logic [7:0]        cfg_byte;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [7:0] last_good = 8'h0F;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_baud_prescaler #(.FREQ_W(FREQ_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .core_hz(core_hz),
        .req_hz(req_hz), .max_hz(max_hz), .busy(busy), .done(done),
        .err(err), .cfg_byte(cfg_byte), .sck(sck), .sck_edge(sck_edge)
    );

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Reference: clamp, ceiling divide, then smallest exponent that fits.
    function automatic void model(input longint core, input longint req, input longint mx,
                                  output bit e_err, output logic [7:0] e_cfg, output longint divn);
        longint rate, m;
        int x;
        rate = (mx != 0 && req > mx) ? mx : req;
        e_err = 0; e_cfg = 8'h00; divn = 0;
        if (rate == 0) begin e_err = 1; return; end
        divn = (core + rate - 1) / rate;
        if (divn < 2) divn = 2;
        x = 0; m = divn;
        while (m > 15) begin
            x++;
            m = (divn + (64'sd1 <<< x) - 1) >>> x;
        end
        if (x > 7) e_err = 1;
        else e_cfg = {x[2:1], 1'b0, x[0], m[3:0]};
    endfunction

    task automatic run_calc(input longint core, input longint req, input longint mx, output int lat);
        @(negedge clk);
        core_hz = core[FREQ_W-1:0]; req_hz = req[FREQ_W-1:0]; max_hz = mx[FREQ_W-1:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done) begin @(negedge clk); lat++; end
    endtask

    task automatic sweep_one(input longint core, input longint req, input longint mx);
        bit e_err; logic [7:0] e_cfg; longint divn; int lat; longint ratio;
        model(core, req, mx, e_err, e_cfg, divn);
        run_calc(core, req, mx, lat);
        chk(err == e_err, "R6", err, e_err);
        if (!e_err) begin
            if (divn < 16) chk(cfg_byte == e_cfg, "R4", cfg_byte, e_cfg);
            else           chk(cfg_byte == e_cfg, "R5", cfg_byte, e_cfg);
            ratio = longint'(cfg_byte[3:0]) << {cfg_byte[7:6], cfg_byte[4]};
            chk(ratio >= divn, "R5", ratio, divn);
            chk(cfg_byte[5] == 1'b0, "R2", cfg_byte[5], 0);
            last_good = e_cfg;
        end else begin
            chk(cfg_byte == last_good, "R6", cfg_byte, last_good);
        end
    endtask

    task automatic measure(output int per, output int hi);
        int c;
        hi = 0;
        do @(negedge clk); while (!(sck_edge && sck));
        c = 0;
        forever begin
            @(negedge clk); c++;
            if (sck_edge && !sck) hi = c;
            if (sck_edge && sck) break;
        end
        per = c;
    endtask

    task automatic gen_case(input longint req);
        bit e_err; logic [7:0] e_cfg; longint divn; int lat, per, hi, oldn, newn;
        oldn = int'(cfg_byte[3:0]) << {cfg_byte[7:6], cfg_byte[4]};
        model(1000, req, 0, e_err, e_cfg, divn);
        newn = int'(e_cfg[3:0]) << {e_cfg[7:6], e_cfg[4]};
        run_calc(1000, req, 0, lat);
        last_good = e_cfg;
        measure(per, hi);
        chk(per == oldn || per == newn, "R8", per, newn);
        for (int k = 0; k < 2; k++) begin
            measure(per, hi);
            chk(per == newn, "R1", per, newn);
            chk(hi == newn / 2, "R1", hi, newn / 2);
        end
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R7 watchdog expired actual=%0d expected=0", WD_CYCLES);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int lat, per, hi;
        bit e_err; logic [7:0] e_cfg; longint divn;
        longint r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state, R7 idle
        chk(cfg_byte == 8'h0F, "R2", cfg_byte, 8'h0F);
        chk(busy == 1'b0, "R7", busy, 0);
        chk(done == 1'b0, "R7", done, 0);
        // R1 reset ratio 15
        measure(per, hi);
        chk(per == 15, "R1", per, 15);
        chk(hi == 7, "R1", hi, 7);

        // R7 latency
        model(1000, 100, 0, e_err, e_cfg, divn);
        run_calc(1000, 100, 0, lat);
        chk(lat == FREQ_W + 1, "R7", lat, FREQ_W + 1);
        chk(cfg_byte == e_cfg, "R4", cfg_byte, e_cfg);
        last_good = e_cfg;
        @(negedge clk);
        chk(done == 1'b0, "R7", done, 0);

        // R4 / R5 sweep over a small core
        for (int q = 1; q <= 800; q++) sweep_one(1000, q, 0);

        // R5 / R6 sweep over a fast core
        r = 200000000;
        while (r > 1000) begin
            sweep_one(200000000, r, 0);
            r = (r * 3) / 4;
        end
        sweep_one(200000000, 200000000 / 1920, 0);
        sweep_one(200000000, 200000000 / 1920 - 1, 0);
        sweep_one(64'hFFFF_FFFF, 1, 0);
        sweep_one(1000, 0, 0);
        sweep_one(64'hFFFF_FFFF, 64'hFFFF_FFFF, 0);
        sweep_one(0, 5, 0);

        // R3 clamp
        sweep_one(1000, 900, 300);
        model(1000, 300, 0, e_err, e_cfg, divn);
        chk(cfg_byte == e_cfg, "R3", cfg_byte, e_cfg);
        sweep_one(1000, 900, 0);
        model(1000, 900, 0, e_err, e_cfg, divn);
        chk(cfg_byte == e_cfg, "R3", cfg_byte, e_cfg);
        sweep_one(1000, 100, 300);
        model(1000, 100, 0, e_err, e_cfg, divn);
        chk(cfg_byte == e_cfg, "R3", cfg_byte, e_cfg);

        // R7 start while busy is ignored
        model(1000, 40, 0, e_err, e_cfg, divn);
        @(negedge clk);
        core_hz = 1000; req_hz = 40; max_hz = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        req_hz = 3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 6;
        while (!done) begin @(negedge clk); lat++; end
        chk(lat == FREQ_W + 1, "R7", lat, FREQ_W + 1);
        chk(cfg_byte == e_cfg, "R7", cfg_byte, e_cfg);
        last_good = e_cfg;
        repeat (40) @(negedge clk);
        chk(busy == 1'b0, "R7", busy, 0);

        // R1 / R8 generator periods and duty
        gen_case(100);
        gen_case(30);
        gen_case(500);
        gen_case(334);
        gen_case(56);
        gen_case(1000);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule